// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block collects level-sensitive interrupt requests from a set of devices and folds them onto four shared interrupt lines. Every device presents four request pins. Each pin is mapped to one line by rotating the pin index by the device's slot number. Devices that sit on a secondary bus behind a bridge are rotated twice: first by their own slot on the secondary bus, then by the bridge's slot on the primary bus.

For each line, a counter holds the number of device pins that currently assert it. The block remembers the last level it saw on every pin. Only a real level change moves a counter, by +1 or -1. A line is driven high while its counter is nonzero. A per-device clear input returns that device's remembered pins to zero, which withdraws that device's contribution to the counters.

Top module: `irq_share_agg`

## Requirements
- R1: Device d drives its pins on `dev_pins` bits [4d+3:4d], where bit 4d+p is pin p (p = 0..3). Primary devices are d = 0..N_PRI-1. Secondary devices are d = N_PRI..N_PRI+N_SEC-1, and each sits at secondary slot d-N_PRI.
- R2: Pin p of primary device d maps to line (p + d) mod 4, which is bit (p + d) mod 4 of `line_o`.
- R3: Pin p of the secondary device at slot s first maps to bridge pin b = (p + s) mod 4, and then to line (b + BR_SLOT) mod 4.
- R4: A pin level sampled at a rising clock edge appears on the line outputs immediately after that edge. A line is high exactly when at least one remembered pin mapped to it is high.
- R5: When a pin is sampled at the level already remembered for it, no counter and no line changes.
- R6: A line that several pins share stays high until the last of those pins drops.
- R7: Several pin changes in the same cycle, including changes on the same line, are all applied at one edge.
- R8: While `dev_clr[d]` is high at an edge, device d's remembered pins become zero and its pin inputs are not used. If a pin is still high at the next edge without clear, it asserts its line again.
- R9: A synchronous reset with `rst_n` low clears all remembered pins and all counters, so every line is low.
- R10: With every pin of every device high, every counter stays within its range and all four lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_pins | input | 4*(N_PRI+N_SEC) | Level of every device interrupt pin |
| dev_clr | input | N_PRI+N_SEC | Per-device clear of remembered pin state |
| line_o | output | 4 | Shared interrupt lines, high while their counter is nonzero |

## Verification
The assertions watch three things on every cycle:
- the counter total always equals the number of remembered high pins;
- a device whose clear was high holds no remembered high pin;
- the lines stay still when the pins have not moved and no clear was given.

The bench scenarios are needed for the rest. Those cover the exact line a given pin reaches on either bus, sharing on one line until the last pin drops, and re-assertion after a clear. They also cover the saturated case with all pins high, which is checked against a reference model under random pin and clear traffic.

// File: rtl/irq_share_pkg.sv
// Package: shared constants and the pin-to-line mapping function.
// Assumes exactly four pins per device and four shared lines.
package irq_share_pkg;
    localparam int PINS_PER_DEV = 4;
    localparam int NUM_LINES    = 4;

    // Line reached by pin p of device d, where a bridge rotates once per bus level.
    function automatic int line_of(input int d, input int p, input int n_pri, input int br_slot);
        int b;
        if (d < n_pri) begin
            return (p + d) % NUM_LINES;
        end
        b = (p + (d - n_pri)) % NUM_LINES;
        return (b + br_slot) % NUM_LINES;
    endfunction
endpackage

// File: rtl/irq_pin_tracker.sv
// Module: remembers the four pin levels of one device and reports rising
// and falling changes against the remembered value.
// Assumes pins are already synchronous to clk; clear overrides the pins.
module irq_pin_tracker #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pins,
    input  logic          clr,
    output logic [NP-1:0] lvl,
    output logic [NP-1:0] rise,
    output logic [NP-1:0] fall
);
    logic [NP-1:0] eff;

    // Effective level: a clear forces the device to look idle.
    always_comb begin
        eff  = clr ? '0 : pins;
        rise = eff & ~lvl;
        fall = ~eff & lvl;
    end

    // Remember the effective level of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl <= '0;
        else        lvl <= eff;
    end
endmodule

// File: rtl/irq_line_counter.sv
// Module: reference counter for one shared line. Adds the number of rising
// pins and subtracts the number of falling pins on each cycle.
// Assumes rise and fall only flag real changes, so the count cannot underflow.
module irq_line_counter #(
    parameter int NPIN = 24,
    parameter int CW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] up,
    input  logic [NPIN-1:0] dn,
    output logic [CW-1:0]   cnt,
    output logic            line
);
    logic [CW-1:0] n_up, n_dn;

    // Population count of rising and falling pins for this line.
    always_comb begin
        n_up = '0;
        n_dn = '0;
        for (int i = 0; i < NPIN; i++) begin
            n_up = n_up + CW'(up[i]);
            n_dn = n_dn + CW'(dn[i]);
        end
    end

    // Apply the summed delta of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + n_up - n_dn;
    end

    // The line is asserted while any pin holds it.
    assign line = (cnt != '0);
endmodule

// File: rtl/irq_share_agg.sv
// Module: top of the shared interrupt aggregator. One tracker per device,
// a fixed pin-to-line routing network, and one counter per line.
// Assumes a single bridge at primary slot BR_SLOT serving N_SEC devices.
module irq_share_agg
    import irq_share_pkg::*;
#(
    parameter int N_PRI   = 4,
    parameter int N_SEC   = 2,
    parameter int BR_SLOT = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [PINS_PER_DEV*(N_PRI+N_SEC)-1:0] dev_pins,
    input  logic [N_PRI+N_SEC-1:0]               dev_clr,
    output logic [NUM_LINES-1:0]                 line_o
);
    localparam int NDEV = N_PRI + N_SEC;
    localparam int NPIN = PINS_PER_DEV * NDEV;
    localparam int CW   = $clog2(NPIN + 1);

    logic [NPIN-1:0]         lvl_all, rise_all, fall_all;
    logic [NUM_LINES*CW-1:0] cnt_flat;

    // One tracker per device.
    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        irq_pin_tracker #(.NP(PINS_PER_DEV)) trk_i (
            .clk  (clk),
            .rst_n(rst_n),
            .pins (dev_pins[d*PINS_PER_DEV +: PINS_PER_DEV]),
            .clr  (dev_clr[d]),
            .lvl  (lvl_all[d*PINS_PER_DEV +: PINS_PER_DEV]),
            .rise (rise_all[d*PINS_PER_DEV +: PINS_PER_DEV]),
            .fall (fall_all[d*PINS_PER_DEV +: PINS_PER_DEV])
        );
    end

    // Route each pin's change flags to the counter of its mapped line.
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [NPIN-1:0] up_v, dn_v;
        for (genvar k = 0; k < NPIN; k++) begin : g_pin
            localparam int TGT = line_of(k / PINS_PER_DEV, k % PINS_PER_DEV, N_PRI, BR_SLOT);
            if (TGT == l) begin : g_hit
                assign up_v[k] = rise_all[k];
                assign dn_v[k] = fall_all[k];
            end else begin : g_miss
                assign up_v[k] = 1'b0;
                assign dn_v[k] = 1'b0;
            end
        end
        irq_line_counter #(.NPIN(NPIN), .CW(CW)) cnt_i (
            .clk  (clk),
            .rst_n(rst_n),
            .up   (up_v),
            .dn   (dn_v),
            .cnt  (cnt_flat[l*CW +: CW]),
            .line (line_o[l])
        );
    end
endmodule

// File: rtl/irq_share_agg_chk.sv
// Checker: temporal properties of the aggregator, bound to the top module.
// Assumes it sees the remembered pin levels and the flattened line counters.
module irq_share_agg_chk #(
    parameter int NDEV = 6,
    parameter int CW   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4*NDEV-1:0]   dev_pins,
    input logic [NDEV-1:0]     dev_clr,
    input logic [3:0]          line_o,
    input logic [4*NDEV-1:0]   lvl_all,
    input logic [4*CW-1:0]     cnt_flat
);
    logic seen;
    int   total;

    // Marks that the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // Sum of all line counters.
    always_comb begin
        total = 0;
        for (int l = 0; l < 4; l++) total += int'(cnt_flat[l*CW +: CW]);
    end

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        total == $countones(lvl_all)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        total <= 4*NDEV); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && dev_pins == $past(dev_pins) && dev_clr == '0 && $past(dev_clr) == '0)
        |=> $stable(line_o)); // R5

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (line_o == 4'b0)); // R9

    for (genvar d = 0; d < NDEV; d++) begin : g_clr
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            dev_clr[d] |=> (lvl_all[d*4 +: 4] == 4'b0)); // R8
    end
endmodule

bind irq_share_agg irq_share_agg_chk #(.NDEV(N_PRI+N_SEC), .CW($clog2(4*(N_PRI+N_SEC)+1))) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_pins(dev_pins),
    .dev_clr (dev_clr),
    .line_o  (line_o),
    .lvl_all (lvl_all),
    .cnt_flat(cnt_flat)
);

// File: tb/irq_share_agg_tb_top.sv
// Bench: directed corner cases plus seeded random traffic, compared against
// a reference model of remembered pin levels and the mapping rule.
module irq_share_agg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_PRI   = 4;
    localparam int N_SEC   = 2;
    localparam int BR_SLOT = 2;
    localparam int NDEV    = N_PRI + N_SEC;
    localparam int NPIN    = 4 * NDEV;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NPIN-1:0] dev_pins;
    logic [NDEV-1:0] dev_clr;
    logic [3:0]      line_o;

    logic [NPIN-1:0] model;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    irq_share_agg #(.N_PRI(N_PRI), .N_SEC(N_SEC), .BR_SLOT(BR_SLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_pins(dev_pins), .dev_clr(dev_clr), .line_o(line_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Line reached by a pin, per R2 and R3.
    function automatic int map_line(input int d, input int p);
        if (d < N_PRI) return (p + d) % 4;
        return (((p + d - N_PRI) % 4) + BR_SLOT) % 4;
    endfunction

    // Expected lines from the modelled remembered pin levels.
    function automatic logic [3:0] exp_lines(input logic [NPIN-1:0] m);
        logic [3:0] r = '0;
        for (int k = 0; k < NPIN; k++) if (m[k]) r[map_line(k/4, k%4)] = 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (line_o !== exp) begin
            fails++;
            $display("FAIL %s: line_o=%b expected=%b", req, line_o, exp);
        end
    endtask

    // Drive one cycle of inputs, update the model, check after the edge.
    task automatic step(input logic [NPIN-1:0] p, input logic [NDEV-1:0] c, input string req);
        @(negedge clk);
        dev_pins = p;
        dev_clr  = c;
        for (int d = 0; d < NDEV; d++) model[d*4 +: 4] = c[d] ? 4'b0 : p[d*4 +: 4];
        @(posedge clk);
        #1;
        check(req, exp_lines(model));
    endtask

    function automatic logic [NPIN-1:0] pin(input int d, input int p);
        logic [NPIN-1:0] v = '0;
        v[d*4 + p] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [NPIN-1:0] p;
        rst_n = 1'b0; dev_pins = '1; dev_clr = '0; model = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset", 4'b0000);
        @(negedge clk); rst_n = 1'b1; dev_pins = '0;
        @(posedge clk); #1;
        check("R9 after release", 4'b0000);

        step(pin(0,0), '0, "R2 d0p0->line0");
        if (line_o !== 4'b0001) begin fails++; $display("FAIL R2: line_o=%b expected=0001", line_o); end
        checks++;
        step(pin(1,0), '0, "R2 d1p0->line1");
        step(pin(3,2), '0, "R2 d3p2->line1");
        step(pin(1,1) | pin(1,3), '0, "R1 d1p1,p3->lines2,0");
        step(pin(4,0), '0, "R3 sec slot0 p0->line2");
        step(pin(5,1), '0, "R3 sec slot1 p1->line0");
        if (line_o !== 4'b0001) begin fails++; $display("FAIL R3: line_o=%b expected=0001", line_o); end
        checks++;
        // Sharing line 0: d0p0, d3p1, d5p1.
        step(pin(0,0) | pin(3,1) | pin(5,1), '0, "R7 three rise together");
        step(pin(0,0) | pin(3,1) | pin(5,1), '0, "R5 same level held");
        step(pin(3,1) | pin(5,1), '0, "R6 one of three drops");
        step(pin(5,1), '0, "R6 one of three left");
        step('0, '0, "R6 last drops");
        // Swap: one rises, another falls on the same line in one cycle.
        step(pin(0,0), '0, "R7 setup");
        step(pin(3,1), '0, "R7 swap same line");
        // Clear with pin still high, then re-assert.
        step(pin(2,1), '0, "R8 setup d2p1->line3");
        step(pin(2,1), 6'b000100, "R8 clear drops line");
        step(pin(2,1), '0, "R8 reassert after clear");
        step(pin(2,1), 6'b000011, "R8 other clear no effect");
        // Saturation.
        step('1, '0, "R10 all pins high");
        step('1, '0, "R10 all held");
        step('0, '0, "R4 all drop");

        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 400; i++) begin
            p = '0;
            for (int k = 0; k < NPIN; k++) p[k] = ($urandom % 3) == 0;
            if (i % 4 == 0) p = dev_pins;
            step(p, (($urandom % 8) == 0) ? NDEV'($urandom) : '0, "R4 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        done = 1;
        $finish;
    end
endmodule